// File: doc/BRIEF.md
# Reloadable Up-Counting Timer with Compare Match

This block is a 32-bit up-counting timer that sits behind a simple word-wide register port. Software writes a load value, a compare value and a control word. Once started, the counter advances on every clock or, with the prescaler enabled, once every 2^(PTV+1) clocks. When the count passes its maximum, the block raises an overflow event and reloads the counter from the load register. When compare is enabled and the count reaches the compare value, the block raises a match event.

Events are recorded in a three-bit status register whose bits are cleared by writing one. A level interrupt line is raised for events whose interrupt-enable bit is set, and it drops once the whole status register is zero. A separate wake-up mask produces a one-cycle wake pulse for the same events. One-cycle overflow and match strobes are also brought out for neighbouring logic. A trigger write forces a reload. A software reset returns every register and mode to zero.

Top module: `reload_timer`

## Requirements
- R1: After reset all registers read zero. Offset 0x14 reads 1. Offsets 0x34, 0x3C, 0x44 and 0x10 read 0.
- R2: With start (control bit 0) set and prescale off, the counter (offset 0x28) gains one per clock. With start clear, it holds its value.
- R3: With prescale enable (control bit 5) set, the counter gains one every 2^(PTV+1) clocks, where PTV is control bits 4:2.
- R4: A tick taken at count 0xFFFFFFFF loads the counter from the load register (0x2C). It sets status bit 1 and gives a one-cycle pulse on `ovf_o` in the cycle the reloaded value is visible.
- R5: If auto-reload (control bit 1) is clear, an overflow also clears the start bit, so the counter stops at the load value.
- R6: With compare enable (control bit 6) set, the tick that brings the count to the match register (0x38) value sets status bit 0 and pulses `match_o`. With compare enable clear, no match event occurs.
- R7: A write to 0x28 sets the count to the written value. Any write to 0x30 copies the load register into the counter. A bus write takes priority over a tick in the same cycle.
- R8: The status register (0x18) holds match at bit 0, overflow at bit 1 and capture at bit 2. Writing 1 to a bit clears it. An event in the same cycle wins over the clear.
- R9: `irq_o` rises only for an event whose bit is set in the interrupt enable register (0x1C, bits 2:0). It falls once all status bits are zero.
- R10: `wake_o` pulses for one cycle for an event whose bit is set in the wake enable register (0x20, bits 2:0).
- R11: The control register (0x24) stores and reads back bits 14:0. Bits 31:15 read as zero.
- R12: Writing 1 to bit 1 at offset 0x10 clears all registers, status, interrupt and modes to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Level interrupt |
| wake_o | output | 1 | One-cycle wake-up pulse |
| ovf_o | output | 1 | One-cycle overflow strobe |
| match_o | output | 1 | One-cycle compare-match strobe |

## Verification
The bench builds the block with its default widths: a 32-bit counter and a 3-bit prescale field. Because the counter can be written directly, the bench reaches overflow by loading values a few steps below 0xFFFFFFFF, so wrap and reload occur within a handful of cycles. Small PTV settings (0 and 1) keep prescaled periods short enough to count the ticks exactly. Match and overflow are placed in one sequence so that the bench can watch the interrupt line survive a partial status clear.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  localparam logic [7:0] OFS_SYSCFG = 8'h10;
  localparam logic [7:0] OFS_RSTOK  = 8'h14;
  localparam logic [7:0] OFS_STAT   = 8'h18;
  localparam logic [7:0] OFS_IEN    = 8'h1C;
  localparam logic [7:0] OFS_WEN    = 8'h20;
  localparam logic [7:0] OFS_CTRL   = 8'h24;
  localparam logic [7:0] OFS_CNT    = 8'h28;
  localparam logic [7:0] OFS_LOAD   = 8'h2C;
  localparam logic [7:0] OFS_TRIG   = 8'h30;
  localparam logic [7:0] OFS_PEND   = 8'h34;
  localparam logic [7:0] OFS_CMP    = 8'h38;
  localparam logic [7:0] OFS_CAP0   = 8'h3C;
  localparam logic [7:0] OFS_CAP1   = 8'h44;

  localparam int EV_MATCH = 0;
  localparam int EV_OVF   = 1;
  localparam int EV_CAPT  = 2;
  localparam int EV_W     = 3;

  // Control word; field order gives the bit positions (bit 0 = run).
  typedef struct packed {
    logic       pin_dir;
    logic       capt_second;
    logic       toggle_sel;
    logic [1:0] trig_mode;
    logic [1:0] capt_mode;
    logic       idle_level;
    logic       cmp_en;
    logic       div_en;
    logic [2:0] div_sel;
    logic       auto_rl;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             div_en_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int DIV_W = 1 << SEL_W;

  logic [DIV_W-1:0] div_q, div_d, lim;
  logic             at_lim;

  always_comb begin
    lim    = (DIV_W'(2) << div_sel_i) - DIV_W'(1);
    at_lim = (div_q == lim);
    tick_o = run_i & (~div_en_i | at_lim);
    if (!run_i || !div_en_i || at_lim) div_d = '0;
    else                               div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R3: a divided tick never repeats on the next clock while division stays on
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_en_i) |=> (!tick_o || !div_en_i));
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             wr_cnt_i,
  input  logic             wr_trig_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o,
  output logic             match_evt_o,
  output logic             ovf_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, step;
  logic             adv, ovf_q, match_q;

  always_comb begin
    adv         = tick_i & ~wr_cnt_i & ~wr_trig_i & ~clr_i;
    step        = (cnt_q == CNT_MAX) ? load_i : cnt_q + CNT_W'(1);
    ovf_evt_o   = adv & (cnt_q == CNT_MAX);
    match_evt_o = adv & cmp_en_i & (step == cmp_i);
    if (clr_i)          cnt_d = '0;
    else if (wr_cnt_i)  cnt_d = wdata_i;
    else if (wr_trig_i) cnt_d = load_i;
    else if (adv)       cnt_d = step;
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_evt_o;
      match_q <= match_evt_o;
    end
  end

  assign cnt_o   = cnt_q;
  assign ovf_o   = ovf_q;
  assign match_o = match_q;

  // R2: no tick and no write means the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_cnt_i && !wr_trig_i && !clr_i) |=> $stable(cnt_q));
  // R4: overflow reloads from the load register
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_o |=> (cnt_q == $past(load_i) && ovf_o));
  // R7: a direct count write lands in the counter
  a_r7_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_i && !clr_i) |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import rtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [EV_W-1:0]   evt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              wr_cnt_o,
  output logic              wr_trig_o,
  output logic              clr_o,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] load_q, load_d, cmp_q, cmp_d;
  logic [EV_W-1:0]  stat_q, stat_d, ien_q, ien_d, wen_q, wen_d, clr_mask;
  logic             irq_q, irq_d, wake_q, wake_d;
  logic             hit;

  function automatic logic sel(input logic [ADDR_W-1:0] a, input logic [7:0] o);
    return a == ADDR_W'(o);
  endfunction

  always_comb begin
    hit       = we_i;
    clr_o     = hit & sel(addr_i, OFS_SYSCFG) & wdata_i[1];
    wr_cnt_o  = hit & sel(addr_i, OFS_CNT);
    wr_trig_o = hit & sel(addr_i, OFS_TRIG);
    clr_mask  = (hit && sel(addr_i, OFS_STAT)) ? wdata_i[EV_W-1:0] : '0;

    ctrl_d = ctrl_q;
    if (evt_i[EV_OVF] && !ctrl_q.auto_rl) ctrl_d.run = 1'b0;
    if (hit && sel(addr_i, OFS_CTRL))     ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0]);
    load_d = (hit && sel(addr_i, OFS_LOAD)) ? wdata_i[CNT_W-1:0] : load_q;
    cmp_d  = (hit && sel(addr_i, OFS_CMP))  ? wdata_i[CNT_W-1:0] : cmp_q;
    ien_d  = (hit && sel(addr_i, OFS_IEN))  ? wdata_i[EV_W-1:0]  : ien_q;
    wen_d  = (hit && sel(addr_i, OFS_WEN))  ? wdata_i[EV_W-1:0]  : wen_q;
    stat_d = (stat_q & ~clr_mask) | evt_i;

    if (|(evt_i & ien_q))  irq_d = 1'b1;
    else if (stat_d == '0) irq_d = 1'b0;
    else                   irq_d = irq_q;
    wake_d = |(evt_i & wen_q);

    if (clr_o) begin
      ctrl_d = '0; load_d = '0; cmp_d = '0; ien_d = '0;
      wen_d  = '0; stat_d = '0; irq_d = 1'b0; wake_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; load_q <= '0; cmp_q <= '0; ien_q <= '0;
      wen_q  <= '0; stat_q <= '0; irq_q <= 1'b0; wake_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d; load_q <= load_d; cmp_q <= cmp_d; ien_q <= ien_d;
      wen_q  <= wen_d;  stat_q <= stat_d; irq_q <= irq_d; wake_q <= wake_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if      (sel(addr_i, OFS_RSTOK)) rdata_o = 32'd1;
    else if (sel(addr_i, OFS_STAT))  rdata_o = 32'(stat_q);
    else if (sel(addr_i, OFS_IEN))   rdata_o = 32'(ien_q);
    else if (sel(addr_i, OFS_WEN))   rdata_o = 32'(wen_q);
    else if (sel(addr_i, OFS_CTRL))  rdata_o = 32'(ctrl_q);
    else if (sel(addr_i, OFS_CNT))   rdata_o = 32'(cnt_i);
    else if (sel(addr_i, OFS_LOAD))  rdata_o = 32'(load_q);
    else if (sel(addr_i, OFS_CMP))   rdata_o = 32'(cmp_q);
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign cmp_o  = cmp_q;
  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  // R9: the interrupt line is never high with an empty status register
  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (stat_q != '0));
  // R10: a wake pulse always follows an enabled event
  a_r10_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(|(evt_i & wen_q)));
  // R8: an event always shows in status on the next cycle
  a_r8_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i != '0) && !clr_o) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
  // R5: a one-shot overflow stops the timer
  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[EV_OVF] && !ctrl_q.auto_rl && !(hit && sel(addr_i, OFS_CTRL)))
      |=> !ctrl_q.run);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              wake_o,
  output logic              ovf_o,
  output logic              match_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load, cmp, cnt;
  logic             wr_cnt, wr_trig, clr, tick, ovf_evt, match_evt;
  logic [EV_W-1:0]  evt;

  assign evt = {1'b0, ovf_evt, match_evt};

  timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .cnt_i(cnt), .evt_i(evt), .ctrl_o(ctrl),
    .load_o(load), .cmp_o(cmp), .wr_cnt_o(wr_cnt), .wr_trig_o(wr_trig),
    .clr_o(clr), .rdata_o(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  timer_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl.run), .div_en_i(ctrl.div_en),
    .div_sel_i(ctrl.div_sel), .tick_o(tick)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick),
    .cmp_en_i(ctrl.cmp_en), .load_i(load), .cmp_i(cmp),
    .wr_cnt_i(wr_cnt), .wr_trig_i(wr_trig), .wdata_i(bus_wdata[CNT_W-1:0]),
    .cnt_o(cnt), .ovf_evt_o(ovf_evt), .match_evt_o(match_evt),
    .ovf_o(ovf_o), .match_o(match_o)
  );
endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wake_o, ovf_o, match_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reload_timer dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", 8'h24, 0); rdchk("R1 cnt", 8'h28, 0);
    rdchk("R1 stat", 8'h18, 0); rdchk("R1 rstok", 8'h14, 1);
    rdchk("R1 pend", 8'h34, 0); rdchk("R1 cap0", 8'h3C, 0);
    rdchk("R1 cap1", 8'h44, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_plain;
    wr(8'h28, 100);
    rdchk("R7 direct write", 8'h28, 100);
    wr(8'h24, 32'h1);
    repeat (5) @(posedge clk);
    rdchk("R2 count per clock", 8'h28, 105);
    wr(8'h24, 32'h0);                  // one more tick at this edge
    cyc(4);
    rdchk("R2 hold when stopped", 8'h28, 106);
  endtask

  task automatic t_prescale;
    wr(8'h28, 0);
    wr(8'h24, 32'h25);                 // run, ptv=1, div_en -> period 4
    repeat (3) @(posedge clk);
    rdchk("R3 before first tick", 8'h28, 0);
    repeat (1) @(posedge clk);
    rdchk("R3 first tick", 8'h28, 1);
    repeat (4) @(posedge clk);
    rdchk("R3 second tick", 8'h28, 2);
    wr(8'h24, 32'h0);
    wr(8'h28, 0);
    wr(8'h24, 32'h21);                 // ptv=0 -> period 2
    repeat (6) @(posedge clk);
    rdchk("R3 period two", 8'h28, 3);
    wr(8'h24, 32'h0);
  endtask

  task automatic t_overflow;
    wr(8'h2C, 32'h10); wr(8'h1C, 32'h2);
    wr(8'h28, 32'hFFFF_FFFE);
    wr(8'h24, 32'h3);                  // run + auto reload
    repeat (2) @(posedge clk);
    rdchk("R4 reload value", 8'h28, 32'h10);
    rdchk("R4 status ovf", 8'h18, 32'h2);
    chk("R4 ovf strobe", ovf_o, 1);
    chk("R9 irq on enabled ovf", irq_o, 1);
    repeat (1) @(posedge clk);
    rdchk("R4 keeps counting", 8'h28, 32'h11);
    chk("R4 strobe one cycle", ovf_o, 0);
    wr(8'h24, 32'h0);
    wr(8'h18, 32'h2);
    rdchk("R8 w1c", 8'h18, 0);
    chk("R9 irq drops", irq_o, 0);
  endtask

  task automatic t_oneshot;
    wr(8'h2C, 32'h20); wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h24, 32'h1);
    cyc(4);
    rdchk("R5 run cleared", 8'h24, 0);
    rdchk("R5 stopped at load", 8'h28, 32'h20);
    chk("R9 irq held by status", irq_o, 1);
    wr(8'h18, 32'h7);
    chk("R9 irq cleared", irq_o, 0);
  endtask

  task automatic t_match;
    wr(8'h1C, 32'h1); wr(8'h38, 5); wr(8'h28, 2);
    wr(8'h24, 32'h41);                 // run + compare enable
    repeat (3) @(posedge clk);
    rdchk("R6 count at match", 8'h28, 5);
    rdchk("R6 status match", 8'h18, 1);
    chk("R6 match strobe", match_o, 1);
    chk("R9 irq on match", irq_o, 1);
    wr(8'h24, 32'h0);
    wr(8'h18, 32'h1);
    wr(8'h28, 2);
    wr(8'h24, 32'h1);                  // compare disabled
    repeat (6) @(posedge clk);
    wr(8'h24, 32'h0);
    rdchk("R6 no match when off", 8'h18, 0);
  endtask

  task automatic t_masks;
    wr(8'h1C, 32'h0); wr(8'h20, 32'h2); wr(8'h2C, 0);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h24, 32'h3);
    repeat (1) @(posedge clk); #1;
    chk("R10 wake pulse", wake_o, 1);
    chk("R9 masked irq stays low", irq_o, 0);
    repeat (1) @(posedge clk); #1;
    chk("R10 wake one cycle", wake_o, 0);
    wr(8'h24, 32'h0);
    rdchk("R8 status set while masked", 8'h18, 32'h2);
    wr(8'h18, 32'h2); wr(8'h20, 0);
    // match then overflow, both enabled
    wr(8'h1C, 32'h3); wr(8'h2C, 32'h40);
    wr(8'h38, 32'hFFFF_FFFE); wr(8'h28, 32'hFFFF_FFFD);
    wr(8'h24, 32'h43);
    repeat (3) @(posedge clk);
    wr(8'h24, 32'h0);
    rdchk("R8 two sources", 8'h18, 32'h3);
    wr(8'h18, 32'h1);
    chk("R9 irq holds on partial clear", irq_o, 1);
    wr(8'h18, 32'h2);
    chk("R9 irq drops when empty", irq_o, 0);
  endtask

  task automatic t_trigger_ctrl;
    wr(8'h2C, 32'h77); wr(8'h28, 3);
    wr(8'h30, 32'hDEAD);
    rdchk("R7 trigger reload", 8'h28, 32'h77);
    wr(8'h24, 32'hFFFF_7FFE);
    rdchk("R11 ctrl readback", 8'h24, 32'h7FFE);
    wr(8'h24, 32'h1);
    wr(8'h28, 32'h55);                 // write wins over tick
    rdchk("R7 write beats tick", 8'h28, 32'h55);
  endtask

  task automatic t_swreset;
    wr(8'h1C, 7); wr(8'h38, 9);
    wr(8'h10, 32'h2);
    rdchk("R12 ctrl", 8'h24, 0); rdchk("R12 cnt", 8'h28, 0);
    rdchk("R12 load", 8'h2C, 0); rdchk("R12 ien", 8'h1C, 0);
    rdchk("R12 cmp", 8'h38, 0);
    cyc(3);
    rdchk("R12 stays stopped", 8'h28, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_prescale();
    t_overflow();
    t_oneshot();
    t_match();
    t_masks();
    t_trigger_ctrl();
    t_swreset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule